// File: doc/BRIEF.md
# Synchronous Presettable Decade Counter

This block is one decimal digit of a synchronous counter. A 4-bit state holds a BCD value from 0 to 9. All four bits change together on the rising clock edge. On that edge the block can do one of four things: clear to zero, take a parallel 4-bit preset, advance by one, or hold its value. Clear and preset are active low and synchronous. Both act whatever the count enables are doing. Counting needs both enables high.

A carry output goes high while the digit sits at nine and the chaining enable is high. Several digits therefore form a wider synchronous counter with no extra gates. Each digit's chaining enable is driven from the previous digit's carry, and all digits share one clock.

A counter with a shorter cycle is made by decoding the count and feeding the result back to the clear input. A preset to one of the six unused codes, or a random power-up value, returns to the decimal sequence within two counting edges.

Top module: `bcd_decade_counter`

## Requirements
- R1: When clear_n is low at a rising edge, q becomes 0000 on that edge, whatever load_n, cnt_en and chain_en are; clear wins over load.
- R2: When clear_n is high and load_n is low at a rising edge, q takes din on that edge (any of the 16 codes), whatever cnt_en and chain_en are; load wins over counting.
- R3: When clear_n and load_n are high and cnt_en and chain_en are both high, q advances by one at the edge, and 9 (1001) is followed by 0.
- R4: When clear_n and load_n are high and either enable is low, q keeps its value across the edge.
- R5: rco is high exactly when chain_en is high and q equals 9 (1001); cnt_en has no effect on rco, and rco follows chain_en with no clock delay.
- R6: When counting, the unused codes move as 10→11→6, 12→13→4 and 14→15→2, so every code reaches 0..9 within two counting edges.
- R7: Changes on clear_n, load_n, cnt_en, chain_en or din between rising edges leave q unchanged until the next rising edge.
- R8: Two digits count 00 through 99 and wrap to 00 when the low digit counts always and the high digit's chain_en is driven by the low digit's rco.
- R9: With clear_n driven low by a decode of q == N-1, the digit counts modulo N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for every state bit |
| clear_n | input | 1 | Synchronous clear to zero, active low |
| load_n | input | 1 | Synchronous preset from din, active low |
| cnt_en | input | 1 | Count enable that does not reach the carry |
| chain_en | input | 1 | Count enable that also gates the carry |
| din | input | 4 | Preset value |
| q | output | 4 | Current digit |
| rco | output | 1 | Carry for the next digit |

## Verification
A wrong next-state entry shows on q at the very edge that uses it. The bench therefore checks q one edge after every preset of each of the 16 codes, and again on the following edge, so a bad recovery path is caught within two clocks. A carry fault shows on rco at once, with no clock needed. The bench sweeps rco over every code and every enable pair, and a two-digit cascade shows a late or missing carry as a wrong tens digit on the step from 09 to 10.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    localparam int DIGIT_W = 4;
    localparam logic [DIGIT_W-1:0] TOP_CODE = DIGIT_W'(9);

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } op_t;

    typedef struct packed {
        digit_t cnt;
    } ctr_state_t;

    // Next code when advancing; unused codes fold back into 0..9.
    function automatic digit_t advance(input digit_t c);
        digit_t r;
        if (c == TOP_CODE)
            r = '0;
        else if (c < TOP_CODE)
            r = c + digit_t'(1);
        else if (!c[0])
            r = c + digit_t'(1);
        else
            r = digit_t'(5'd17 - {1'b0, c});
        return r;
    endfunction
endpackage

// File: rtl/bcd_ctrl.sv
module bcd_ctrl
    import bcd_pkg::*;
(
    input  logic clear_n,
    input  logic load_n,
    input  logic cnt_en,
    input  logic chain_en,
    output op_t  op
);
    always_comb begin
        if (!clear_n)
            op = OP_CLEAR;
        else if (!load_n)
            op = OP_LOAD;
        else if (cnt_en && chain_en)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end
endmodule

// File: rtl/bcd_next.sv
module bcd_next
    import bcd_pkg::*;
(
    input  op_t    op,
    input  digit_t cur,
    input  digit_t preset,
    output digit_t nxt
);
    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = preset;
            OP_COUNT: nxt = advance(cur);
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/bcd_carry.sv
module bcd_carry
    import bcd_pkg::*;
(
    input  digit_t cur,
    input  logic   chain_en,
    output logic   carry
);
    logic at_top;
    assign at_top = (cur == TOP_CODE);
    assign carry  = at_top & chain_en;
endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
    import bcd_pkg::*;
(
    input  logic                clk,
    input  logic                clear_n,
    input  logic                load_n,
    input  logic                cnt_en,
    input  logic                chain_en,
    input  logic [DIGIT_W-1:0]  din,
    output logic [DIGIT_W-1:0]  q,
    output logic                rco
);
    op_t        op_w;
    digit_t     nxt_w;
    ctr_state_t st_d, st_q;

    bcd_ctrl u_ctrl (
        .clear_n (clear_n),
        .load_n  (load_n),
        .cnt_en  (cnt_en),
        .chain_en(chain_en),
        .op      (op_w)
    );

    bcd_next u_next (
        .op    (op_w),
        .cur   (st_q.cnt),
        .preset(din),
        .nxt   (nxt_w)
    );

    bcd_carry u_carry (
        .cur     (st_q.cnt),
        .chain_en(chain_en),
        .carry   (rco)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = nxt_w;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.cnt;

    // Port-level view of the mode, for the checks below.
    logic adv_now;
    assign adv_now = clear_n && load_n && cnt_en && chain_en;

    p_clear_r1: assert property (@(posedge clk)
        !clear_n |=> (q == '0));

    p_load_r2: assert property (@(posedge clk)
        (clear_n && !load_n) |=> (q == $past(din)));

    p_count_r3: assert property (@(posedge clk) disable iff ($isunknown(q))
        (adv_now && q <= TOP_CODE) |=>
            (q == (($past(q) == TOP_CODE) ? '0 : $past(q) + digit_t'(1))));

    p_hold_r4: assert property (@(posedge clk) disable iff ($isunknown(q))
        (clear_n && load_n && !(cnt_en && chain_en)) |=> $stable(q));

    p_rco_r5: assert property (@(posedge clk) disable iff ($isunknown(q))
        rco == (chain_en && q == TOP_CODE));

    p_recover_r6: assert property (@(posedge clk) disable iff ($isunknown(q))
        (adv_now && q > TOP_CODE) ##1 adv_now |=> (q <= TOP_CODE));
endmodule

// File: tb/bcd_decade_counter_test.sv
module bcd_decade_counter_test;
    localparam int PERIOD   = 10;
    localparam int WATCHDOG = 20000;
    localparam int MOD_N    = 6;

    logic clk = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    logic       clear_n = 1'b1, load_n = 1'b1, cnt_en = 1'b0, chain_en = 1'b0;
    logic [3:0] din = 4'd0;
    logic [3:0] q;
    logic       rco;

    bcd_decade_counter uut (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .din(din), .q(q), .rco(rco)
    );

    // two-digit cascade
    logic       cas_clr_n = 1'b1;
    logic [3:0] q_lo, q_hi;
    logic       rco_lo, rco_hi;
    bcd_decade_counter u_lo (
        .clk(clk), .clear_n(cas_clr_n), .load_n(1'b1), .cnt_en(1'b1),
        .chain_en(1'b1), .din(4'd0), .q(q_lo), .rco(rco_lo)
    );
    bcd_decade_counter u_hi (
        .clk(clk), .clear_n(cas_clr_n), .load_n(1'b1), .cnt_en(1'b1),
        .chain_en(rco_lo), .din(4'd0), .q(q_hi), .rco(rco_hi)
    );

    // modulo-N by decoding the count
    logic       mod_start_n = 1'b1;
    logic [3:0] q_mod;
    logic       rco_mod;
    logic       mod_clr_n;
    assign mod_clr_n = mod_start_n && (q_mod != 4'(MOD_N - 1));
    bcd_decade_counter u_mod (
        .clk(clk), .clear_n(mod_clr_n), .load_n(1'b1), .cnt_en(1'b1),
        .chain_en(1'b1), .din(4'd0), .q(q_mod), .rco(rco_mod)
    );

    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one rising edge, then return at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int model_adv(input int v);
        if (v == 9) return 0;
        if (v < 9) return v + 1;
        if (v % 2 == 0) return v + 1;
        return 17 - v;
    endfunction

    task automatic preset(input int v);
        clear_n = 1; load_n = 0; din = 4'(v); cnt_en = 0; chain_en = 0;
        step();
        load_n = 1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // reset state through synchronous clear
        clear_n = 0; load_n = 0; cnt_en = 1; chain_en = 1; din = 4'd7;
        step();
        chk("R1 clear at start", q, 0);
        clear_n = 1; load_n = 1; cnt_en = 0; chain_en = 0;

        // R2, R3, R6: preset every code, then two counting edges
        for (int v = 0; v < 16; v++) begin
            preset(v);
            chk("R2 preset value", q, v);
            cnt_en = 1; chain_en = 1;
            step();
            chk("R3/R6 first advance", q, model_adv(v));
            step();
            chk("R3/R6 second advance", q, model_adv(model_adv(v)));
            chk("R6 valid in two edges", int'(q <= 9), 1);
            cnt_en = 0; chain_en = 0;
        end

        // R1, R2, R3, R4: every control combination from a start of 5
        for (int m = 0; m < 16; m++) begin
            int exp_v;
            preset(5);
            clear_n = m[3]; load_n = m[2]; cnt_en = m[1]; chain_en = m[0];
            din = 4'd3;
            step();
            if (!m[3])              exp_v = 0;
            else if (!m[2])         exp_v = 3;
            else if (m[1] && m[0])  exp_v = 6;
            else                    exp_v = 5;
            chk("R1/R2/R3/R4 priority", q, exp_v);
            clear_n = 1; load_n = 1; cnt_en = 0; chain_en = 0;
        end

        // R4: hold over several edges at code 9 with one enable low
        preset(9);
        cnt_en = 1; chain_en = 0;
        step(); step();
        chk("R4 hold with chain_en low", q, 9);
        cnt_en = 0; chain_en = 1;
        step();
        chk("R4 hold with cnt_en low", q, 9);
        cnt_en = 0; chain_en = 0;

        // R5: carry for every code and enable pair, no clock in between
        for (int v = 0; v < 16; v++) begin
            preset(v);
            for (int e = 0; e < 4; e++) begin
                cnt_en = e[1]; chain_en = e[0];
                #1;
                chk("R5 carry", rco, int'(e[0] && v == 9));
            end
            cnt_en = 0; chain_en = 0;
        end

        // R7: control and data changes between edges leave q alone
        preset(4);
        clear_n = 0; din = 4'd8; load_n = 0; cnt_en = 1; chain_en = 1;
        #(PERIOD/4);
        chk("R7 no change between edges", q, 4);
        clear_n = 1; load_n = 1; cnt_en = 0; chain_en = 0;
        #(PERIOD/8);
        chk("R7 still unchanged", q, 4);
        step();
        chk("R7 hold after restore", q, 4);

        // R8: two-digit cascade
        cas_clr_n = 0;
        step();
        cas_clr_n = 1;
        chk("R8 cascade cleared", q_hi * 10 + q_lo, 0);
        for (int i = 1; i <= 101; i++) begin
            step();
            chk("R8 cascade value", q_hi * 10 + q_lo, i % 100);
        end

        // R9: modulo-N through decoded clear
        mod_start_n = 0;
        step();
        mod_start_n = 1;
        for (int i = 1; i <= 3 * MOD_N; i++) begin
            step();
            chk("R9 modulo count", q_mod, i % MOD_N);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule